// File: doc/BRIEF.md
# Coupled Branch Target Buffer

This block predicts the next fetch address in the same cycle that the fetch address is presented. It is a direct-mapped table with tags. Each entry holds two things: the full target address of a branch and a two-bit saturating counter that predicts whether that branch is taken. The table is read with the current fetch PC alongside the instruction cache. The result is a hit flag, a taken prediction and the address to fetch next, all available before decode.

Every resolved branch is written back through the update port, whether it was taken or not. A branch that is not in the table is allocated. A branch that is already present has its target overwritten and its counter moved one step toward the resolved outcome. A lookup that misses predicts not taken and falls through to PC + 4. A lookup that hits follows its entry's counter.

Top module: `coupled_btb`

## Requirements
- R1: After synchronous reset, every lookup misses: `hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R2: A lookup whose indexed entry is invalid, or whose stored tag differs from `fetch_pc[PC_W-1:IDX_W+2]`, gives `hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R3: An update (`upd_valid`=1) whose branch PC misses allocates the entry at index `upd_pc[IDX_W+1:2]`. The allocation stores the tag and `upd_target`, whether the branch was taken or not. The counter is seeded to 2 (weakly taken) if `upd_taken`=1 and to 1 (weakly not taken) otherwise.
- R4: On a hit, `pred_taken` is bit 1 of the entry's counter, where counter values 0..3 run from strongly not taken to strongly taken. `next_pc` is the stored target when `pred_taken`=1 and `fetch_pc`+4 otherwise.
- R5: An update that hits moves the entry's counter by +1 when the branch was taken and by -1 when it was not, saturating at 3 and at 0.
- R6: An update that hits rewrites the stored target with `upd_target`, so a wrong stored target is corrected.
- R7: Two PCs that share an index but differ in tag never alias. Allocating one of them evicts the other, and the evicted PC then misses.
- R8: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.
- R9: When `upd_valid`=0, the table is left unchanged whatever the other update inputs carry.
- R10: The lookup is combinational. The outputs follow a change of `fetch_pc` within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; invalidates all entries |
| fetch_pc | input | PC_W | Fetch address being looked up |
| upd_valid | input | 1 | Resolved-branch update strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_target | input | PC_W | Resolved target address of the branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| hit | output | 1 | Fetch PC matches a valid entry |
| pred_taken | output | 1 | Branch predicted taken |
| next_pc | output | PC_W | Predicted next fetch address |

## Verification
The bench walks one counter through its full trajectory, including repeated steps at both saturation ends. A counter that wrapped instead of saturating would flip its prediction after a run of identical outcomes. It also checks that a not-taken allocation is seeded to 1 and a taken one to 2; a wrong seed would show up as a prediction that is wrong on the first re-encounter or that takes an extra update to settle. Two PCs that share an index are alternated to expose tag truncation or a missing eviction, and a lookup is paired with an update to the same entry in one cycle to catch write-through. A long pseudo-random run over a small set of tags is checked against an arithmetic model of the table. A stale-target bug or a valid bit that is never set would diverge from that model quickly.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Two-bit outcome counter: 0 strongly not taken ... 3 strongly taken.
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    // Counter value given to a freshly allocated entry.
    function automatic ctr_e ctr_seed(input logic taken);
        return taken ? CTR_WT : CTR_WNT;
    endfunction

    // Saturating move toward the resolved outcome.
    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken && cur != CTR_ST)
            nxt = ctr_e'(cur + 2'd1);
        else if (!taken && cur != CTR_SNT)
            nxt = ctr_e'(cur - 2'd1);
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W   = PC_W - IDX_W - 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    // lookup read port
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_target,
    output ctr_e             rd_ctr,
    // update query read port
    input  logic [IDX_W-1:0] uq_idx,
    output logic             uq_valid,
    output logic [TAG_W-1:0] uq_tag,
    output ctr_e             uq_ctr,
    // write port
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  ctr_e             wr_ctr
);

    logic [ENTRIES-1:0] valid_vec;
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic [PC_W-1:0]    tgt_arr [ENTRIES];
    ctr_e               ctr_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             v_q;
        logic [TAG_W-1:0] tag_q;
        logic [PC_W-1:0]  tgt_q;
        ctr_e             ctr_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q <= wr_tag;
                tgt_q <= wr_target;
                ctr_q <= wr_ctr;
            end
        end

        assign valid_vec[g] = v_q;
        assign tag_arr[g]   = tag_q;
        assign tgt_arr[g]   = tgt_q;
        assign ctr_arr[g]   = ctr_q;
    end

    assign rd_valid  = valid_vec[rd_idx];
    assign rd_tag    = tag_arr[rd_idx];
    assign rd_target = tgt_arr[rd_idx];
    assign rd_ctr    = ctr_arr[rd_idx];

    assign uq_valid  = valid_vec[uq_idx];
    assign uq_tag    = tag_arr[uq_idx];
    assign uq_ctr    = ctr_arr[uq_idx];

endmodule

// File: rtl/btb_predict.sv
module btb_predict
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             ent_valid,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_target,
    input  ctr_e             ent_ctr,
    output logic             hit,
    output logic             pred_taken,
    output logic [PC_W-1:0]  next_pc
);

    logic [TAG_W-1:0] look_tag;
    logic [PC_W-1:0]  fall_through;

    assign look_tag     = fetch_pc[PC_W-1:IDX_W+2];
    assign fall_through = fetch_pc + PC_W'(4);

    always_comb begin
        hit        = ent_valid && (ent_tag == look_tag);
        pred_taken = hit && ctr_says_taken(ent_ctr);
        next_pc    = pred_taken ? ent_target : fall_through;
    end

endmodule

// File: rtl/btb_train.sv
module btb_train
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [PC_W-1:0]  upd_target,
    input  logic             upd_taken,
    input  logic             cur_valid,
    input  logic [TAG_W-1:0] cur_tag,
    input  ctr_e             cur_ctr,
    output logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] wr_tag,
    output logic [PC_W-1:0]  wr_target,
    output ctr_e             wr_ctr
);

    logic present;

    assign wr_idx    = upd_pc[IDX_W+1:2];
    assign wr_tag    = upd_pc[PC_W-1:IDX_W+2];
    assign wr_target = upd_target;
    assign present   = cur_valid && (cur_tag == wr_tag);

    always_comb begin
        if (present)
            wr_ctr = ctr_step(cur_ctr, upd_taken);
        else
            wr_ctr = ctr_seed(upd_taken);
    end

endmodule

// File: rtl/coupled_btb.sv
module coupled_btb
    import btb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_target,
    input  logic            upd_taken,
    output logic            hit,
    output logic            pred_taken,
    output logic [PC_W-1:0] next_pc
);

    localparam int TAG_W = PC_W - IDX_W - 2;

    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [PC_W-1:0]  rd_target;
    ctr_e             rd_ctr;

    logic             uq_valid;
    logic [TAG_W-1:0] uq_tag;
    ctr_e             uq_ctr;

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [PC_W-1:0]  wr_target;
    ctr_e             wr_ctr;

    btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (fetch_pc[IDX_W+1:2]),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_target (rd_target),
        .rd_ctr    (rd_ctr),
        .uq_idx    (wr_idx),
        .uq_valid  (uq_valid),
        .uq_tag    (uq_tag),
        .uq_ctr    (uq_ctr),
        .wr_en     (upd_valid),
        .wr_idx    (wr_idx),
        .wr_tag    (wr_tag),
        .wr_target (wr_target),
        .wr_ctr    (wr_ctr)
    );

    btb_predict #(.PC_W(PC_W), .IDX_W(IDX_W)) u_predict (
        .fetch_pc   (fetch_pc),
        .ent_valid  (rd_valid),
        .ent_tag    (rd_tag),
        .ent_target (rd_target),
        .ent_ctr    (rd_ctr),
        .hit        (hit),
        .pred_taken (pred_taken),
        .next_pc    (next_pc)
    );

    btb_train #(.PC_W(PC_W), .IDX_W(IDX_W)) u_train (
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken),
        .cur_valid  (uq_valid),
        .cur_tag    (uq_tag),
        .cur_ctr    (uq_ctr),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_target  (wr_target),
        .wr_ctr     (wr_ctr)
    );

endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic [PC_W-1:0] upd_target,
    input logic            hit,
    input logic            pred_taken,
    input logic [PC_W-1:0] next_pc
);

    // Set once a full cycle outside reset has been sampled.
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_empty_after_reset_R1: assert property (
        @(posedge clk) disable iff (rst)
        $fell(rst) |-> !hit
    );

    assert_miss_falls_through_R2: assert property (
        @(posedge clk) disable iff (rst)
        !hit |-> (!pred_taken && next_pc == fetch_pc + PC_W'(4))
    );

    assert_updated_pc_hits_R3: assert property (
        @(posedge clk) disable iff (rst)
        (armed && $past(upd_valid) && fetch_pc == $past(upd_pc)) |-> hit
    );

    assert_taken_uses_new_target_R6: assert property (
        @(posedge clk) disable iff (rst)
        (armed && $past(upd_valid) && fetch_pc == $past(upd_pc) && pred_taken)
            |-> next_pc == $past(upd_target)
    );

    assert_taken_implies_hit_R4: assert property (
        @(posedge clk) disable iff (rst)
        pred_taken |-> hit
    );

endmodule

bind coupled_btb btb_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_target (upd_target),
    .hit        (hit),
    .pred_taken (pred_taken),
    .next_pc    (next_pc)
);

// File: tb/coupled_btb_tb.sv
`timescale 1ns/1ps
module coupled_btb_tb;

    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam int NENT  = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic [PC_W-1:0] upd_target = '0;
    logic            upd_taken = 1'b0;
    logic            hit;
    logic            pred_taken;
    logic [PC_W-1:0] next_pc;

    int total = 0;
    int bad   = 0;

    // Bench model of the table
    logic             m_v   [NENT];
    logic [TAG_W-1:0] m_tag [NENT];
    logic [PC_W-1:0]  m_tgt [NENT];
    int               m_ctr [NENT];

    always #2 clk = ~clk;

    coupled_btb #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .fetch_pc   (fetch_pc),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_target (upd_target),
        .upd_taken  (upd_taken),
        .hit        (hit),
        .pred_taken (pred_taken),
        .next_pc    (next_pc)
    );

    function automatic logic [PC_W-1:0] mkpc(input int idx, input int tag);
        return {TAG_W'(tag), IDX_W'(idx), 2'b00};
    endfunction

    task automatic check_look(input string req);
        int i;
        logic eh, et;
        logic [PC_W-1:0] en;
        i  = int'(fetch_pc[IDX_W+1:2]);
        eh = m_v[i] && (m_tag[i] == fetch_pc[PC_W-1:IDX_W+2]);
        et = eh && (m_ctr[i] >= 2);
        en = et ? m_tgt[i] : fetch_pc + 32'd4;
        total++;
        if (hit !== eh || pred_taken !== et || next_pc !== en) begin
            bad++;
            $display("FAIL %s pc=%h actual hit=%b taken=%b next=%h expected hit=%b taken=%b next=%h",
                     req, fetch_pc, hit, pred_taken, next_pc, eh, et, en);
        end
    endtask

    task automatic model_update(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt,
                                input logic tk);
        int i;
        i = int'(pc[IDX_W+1:2]);
        if (m_v[i] && m_tag[i] == pc[PC_W-1:IDX_W+2]) begin
            m_tgt[i] = tgt;
            if (tk) m_ctr[i] = (m_ctr[i] == 3) ? 3 : m_ctr[i] + 1;
            else    m_ctr[i] = (m_ctr[i] == 0) ? 0 : m_ctr[i] - 1;
        end else begin
            m_v[i]   = 1'b1;
            m_tag[i] = pc[PC_W-1:IDX_W+2];
            m_tgt[i] = tgt;
            m_ctr[i] = tk ? 2 : 1;
        end
    endtask

    // One cycle: drive lookup and update, check before the edge, apply model after.
    task automatic cyc(input logic [PC_W-1:0] pc, input logic uv,
                       input logic [PC_W-1:0] upc, input logic [PC_W-1:0] utgt,
                       input logic utk, input string req);
        @(negedge clk);
        fetch_pc   = pc;
        upd_valid  = uv;
        upd_pc     = upc;
        upd_target = utgt;
        upd_taken  = utk;
        #1;
        check_look(req);
        @(posedge clk);
        if (uv) model_update(upc, utgt, utk);
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string req);
        cyc(pc, 1'b0, '0, '0, 1'b0, req);
    endtask

    task automatic upd(input logic [PC_W-1:0] upc, input logic [PC_W-1:0] utgt,
                       input logic utk, input string req);
        cyc(upc + 32'h0000_0040, 1'b1, upc, utgt, utk, req);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] p, q;
        logic [15:0] lfsr;
        for (int i = 0; i < NENT; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: empty table after reset
        for (int i = 0; i < NENT; i++) look(mkpc(i, 0), "R1");

        // R3: allocate every index, odd ones taken, even ones not taken
        for (int i = 0; i < NENT; i++)
            upd(mkpc(i, 5), 32'h1000_0000 + 32'(i) * 32'h40, i[0], "R3");
        // R4: hits follow counter bit 1
        for (int i = 0; i < NENT; i++) look(mkpc(i, 5), "R4");
        // R2: unrelated tags miss
        for (int i = 0; i < NENT; i++) look(mkpc(i, 100 + i), "R2");

        // R5: walk one counter through both saturation ends (seeded at 2)
        p = mkpc(3, 5);
        cyc(p, 1'b1, p, 32'h1000_00c0, 1'b1, "R5");
        cyc(p, 1'b1, p, 32'h1000_00c0, 1'b1, "R5");
        cyc(p, 1'b1, p, 32'h1000_00c0, 1'b1, "R5");
        for (int k = 0; k < 5; k++) cyc(p, 1'b1, p, 32'h1000_00c0, 1'b0, "R5");
        cyc(p, 1'b1, p, 32'h1000_00c0, 1'b1, "R5");
        cyc(p, 1'b1, p, 32'h1000_00c0, 1'b1, "R5");
        look(p, "R5");

        // R6: hit update rewrites the target
        upd(p, 32'h2222_0000, 1'b1, "R6");
        look(p, "R6");

        // R7: same index, other tag misses; allocating it evicts the first
        q = mkpc(3, 9);
        look(q, "R7");
        upd(q, 32'h3333_0000, 1'b1, "R7");
        look(q, "R7");
        look(p, "R7");

        // R8: lookup and update to the same entry in one cycle see old contents
        p = mkpc(7, 20);
        cyc(p, 1'b1, p, 32'h4444_0000, 1'b1, "R8");
        look(p, "R8");
        cyc(p, 1'b1, p, 32'h5555_0000, 1'b0, "R8");
        look(p, "R8");

        // R9: upd_valid low leaves the table untouched
        p = mkpc(8, 5);
        cyc(mkpc(9, 5), 1'b0, p, 32'hdead_0000, 1'b0, "R9");
        look(p, "R9");
        cyc(mkpc(9, 5), 1'b0, mkpc(8, 77), 32'hbeef_0000, 1'b1, "R9");
        look(mkpc(8, 77), "R9");

        // R10: outputs follow fetch_pc within one cycle
        @(negedge clk);
        fetch_pc = mkpc(1, 5);
        #0.5 check_look("R10");
        fetch_pc = mkpc(1, 6);
        #0.5 check_look("R10");
        fetch_pc = mkpc(2, 5);
        #0.5 check_look("R10");

        // Pseudo-random sweep over a small tag space against the model (R4, R5)
        lfsr = 16'hace1;
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            p = mkpc(int'(lfsr[3:0]), int'(lfsr[5:4]));
            q = mkpc(int'(lfsr[9:6]), int'(lfsr[11:10]));
            cyc(p, lfsr[12], q, {16'h6000, lfsr}, lfsr[14] ^ lfsr[7], "R4");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule